// File: doc/BRIEF.md
# Three-Wire Serial Register Loader

This block receives configuration words over a write-only three-wire serial port made of a serial clock, a data line and a load strobe. It holds these words in four parallel latches. All three serial lines, and the chip-enable pin, pass through a two-flop synchronizer into the system clock domain. The block detects edges there.

Each rising edge of the serial clock shifts one data bit into a 24-bit register, most significant bit first. When the load strobe rises, the register contents go to one of four latches. The two lowest bits of the word choose the latch. Each latch drives its upper 22 bits on a parallel bus, and a one-cycle update pulse marks every write.

The power-down output is active when chip-enable is low, or when a designated bit in latch 0 is set. The charge-pump tri-state flag follows the power-down output.

Top module: `serial_reg_loader`

## Requirements
- R1: Each rising edge of the synchronized serial clock shifts the synchronized data bit into bit 0 of a 24-bit shift register, and the older bits move one place up. A word sent most significant bit first therefore ends with its first bit at position 23.
- R2: On a load, word bits [1:0] select the latch, with value k addressing latch k. Word bits [23:2] then appear on `latch_data_o[k]`, where word bit 2 maps to payload bit 0.
- R3: A transfer happens only on a rising edge of the synchronized load strobe. Holding the strobe high causes no further transfer, and the latches that are not addressed keep their contents.
- R4: Each transfer raises `latch_upd_o[k]` of the addressed latch for exactly one clock cycle. At most one update bit is high in any cycle.
- R5: A load strobe edge with no new serial bits still transfers the current shift register contents, because the bits are not counted.
- R6: Reset clears the shift register, all four latches and all update pulses to zero.
- R7: `pwr_down_o` is 1 when the synchronized chip-enable is low. It is also 1 when payload bit 19 of latch 0 is set, which is word bit 21 of a word written with address 0. Otherwise it is 0.
- R8: `cp_tristate_o` is 1 exactly when `pwr_down_o` is 1, so a low chip-enable always places the charge pump in its high-impedance state.
- R9: When a serial clock rising edge and a load strobe rising edge reach the same system clock cycle after synchronization, the shift happens first. The transferred word then already contains the new bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock, asynchronous |
| ser_data_i | input | 1 | Serial data, asynchronous |
| ser_le_i | input | 1 | Load strobe, asynchronous |
| chip_en_i | input | 1 | Chip enable, asynchronous, high = enabled |
| latch_data_o | output | 4x22 | Payload of each latch (packed, latch k at index k) |
| latch_upd_o | output | 4 | One-cycle write pulse per latch |
| pwr_down_o | output | 1 | Power-down indication |
| cp_tristate_o | output | 1 | Charge-pump high-impedance request |

## Verification
The last serial clock edge and the load strobe edge can land in the same synchronized cycle. In that case the shift and the transfer must resolve in order. The bench provokes this by raising the serial clock and the load strobe on the same stimulus edge for the final bit of a word. It then checks that the addressed latch holds the complete new word, not the word shifted one place short. Randomly chosen words use this coincident ending at random. The bench model always predicts the full word, so any ordering slip shows up as a wrong payload or as a write to the wrong latch.

// File: rtl/serload_pkg.sv
package serload_pkg;
    localparam int WORD_W    = 24;
    localparam int CTRL_W    = 2;
    localparam int NUM_LATCH = 1 << CTRL_W;
    localparam int PAY_W     = WORD_W - CTRL_W;

    // bit positions of the synchronized input bundle
    localparam int IN_SCLK = 0;
    localparam int IN_DATA = 1;
    localparam int IN_LE   = 2;
    localparam int IN_CE   = 3;
    localparam int IN_W    = 4;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [PAY_W-1:0]  pay_t;
    typedef logic [CTRL_W-1:0] addr_t;
endpackage

// File: rtl/serload_sync.sv
module serload_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d    = chain_q;
        chain_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/serload_shifter.sv
module serload_shifter
    import serload_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  sclk_i,
    input  logic  sdata_i,
    input  logic  sle_i,
    output logic  load_o,
    output word_t load_word_o
);
    typedef struct packed {
        logic  sclk_prev;
        logic  le_prev;
        word_t sr;
        logic  load;
        word_t load_word;
    } shift_state_t;

    shift_state_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.load      = 1'b0;
        st_d.sclk_prev = sclk_i;
        st_d.le_prev   = sle_i;
        // shift first, so a coincident load sees the new bit
        if (sclk_i && !st_q.sclk_prev) begin
            st_d.sr = {st_q.sr[WORD_W-2:0], sdata_i};
        end
        if (sle_i && !st_q.le_prev) begin
            st_d.load      = 1'b1;
            st_d.load_word = st_d.sr;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign load_o      = st_q.load;
    assign load_word_o = st_q.load_word;
endmodule

// File: rtl/serload_latch_bank.sv
module serload_latch_bank
    import serload_pkg::*;
(
    input  logic                             clk_i,
    input  logic                             rst_ni,
    input  logic                             load_i,
    input  word_t                            word_i,
    output logic [NUM_LATCH-1:0][PAY_W-1:0]  latch_o,
    output logic [NUM_LATCH-1:0]             upd_o
);
    typedef struct packed {
        pay_t pay;
        logic upd;
    } slot_t;

    for (genvar g = 0; g < NUM_LATCH; g++) begin : g_slot
        slot_t slot_d, slot_q;
        logic  hit;

        assign hit = load_i && (word_i[CTRL_W-1:0] == addr_t'(g));

        always_comb begin
            slot_d     = slot_q;
            slot_d.upd = hit;
            if (hit) begin
                slot_d.pay = word_i[WORD_W-1:CTRL_W];
            end
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                slot_q <= '0;
            end else begin
                slot_q <= slot_d;
            end
        end

        assign latch_o[g] = slot_q.pay;
        assign upd_o[g]   = slot_q.upd;
    end
endmodule

// File: rtl/serload_power.sv
module serload_power (
    input  logic ce_sync_i,
    input  logic pd_bit_i,
    output logic pwr_down_o,
    output logic cp_tristate_o
);
    logic pd_d;

    always_comb begin
        pd_d          = !ce_sync_i || pd_bit_i;
        pwr_down_o    = pd_d;
        cp_tristate_o = pd_d;
    end
endmodule

// File: rtl/serial_reg_loader.sv
module serial_reg_loader
    import serload_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int PD_LATCH    = 0,
    parameter int PD_BIT      = 19
) (
    input  logic                            clk_i,
    input  logic                            rst_ni,
    input  logic                            ser_clk_i,
    input  logic                            ser_data_i,
    input  logic                            ser_le_i,
    input  logic                            chip_en_i,
    output logic [NUM_LATCH-1:0][PAY_W-1:0] latch_data_o,
    output logic [NUM_LATCH-1:0]            latch_upd_o,
    output logic                            pwr_down_o,
    output logic                            cp_tristate_o
);
    logic [IN_W-1:0] raw_in, sync_in;
    logic            load;
    word_t           load_word;

    always_comb begin
        raw_in          = '0;
        raw_in[IN_SCLK] = ser_clk_i;
        raw_in[IN_DATA] = ser_data_i;
        raw_in[IN_LE]   = ser_le_i;
        raw_in[IN_CE]   = chip_en_i;
    end

    serload_sync #(
        .WIDTH  (IN_W),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (raw_in),
        .sync_o  (sync_in)
    );

    serload_shifter shift_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .sclk_i      (sync_in[IN_SCLK]),
        .sdata_i     (sync_in[IN_DATA]),
        .sle_i       (sync_in[IN_LE]),
        .load_o      (load),
        .load_word_o (load_word)
    );

    serload_latch_bank bank_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (load),
        .word_i  (load_word),
        .latch_o (latch_data_o),
        .upd_o   (latch_upd_o)
    );

    serload_power power_i (
        .ce_sync_i     (sync_in[IN_CE]),
        .pd_bit_i      (latch_data_o[PD_LATCH][PD_BIT]),
        .pwr_down_o    (pwr_down_o),
        .cp_tristate_o (cp_tristate_o)
    );
endmodule

// File: rtl/serload_checker.sv
module serload_checker
    import serload_pkg::*;
(
    input logic                            clk_i,
    input logic                            rst_ni,
    input logic                            chip_en_i,
    input logic [NUM_LATCH-1:0][PAY_W-1:0] latch_data_o,
    input logic [NUM_LATCH-1:0]            latch_upd_o,
    input logic                            pwr_down_o,
    input logic                            cp_tristate_o
);
    // R4
    upd_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(latch_upd_o));

    // R4
    upd_single_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|latch_upd_o) |=> !(|latch_upd_o));

    // R3
    latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(latch_data_o) |-> (|latch_upd_o));

    // R7
    ce_low_pd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!chip_en_i && $past(!chip_en_i) && $past(!chip_en_i, 2)) |-> pwr_down_o);

    // R8
    ce_low_tristate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!chip_en_i && $past(!chip_en_i) && $past(!chip_en_i, 2)) |-> cp_tristate_o);

    // R6
    reset_clear_chk: assert property (@(posedge clk_i)
        (!rst_ni && $past(!rst_ni)) |-> (latch_data_o == '0 && latch_upd_o == '0));
endmodule

bind serial_reg_loader serload_checker chk_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .chip_en_i     (chip_en_i),
    .latch_data_o  (latch_data_o),
    .latch_upd_o   (latch_upd_o),
    .pwr_down_o    (pwr_down_o),
    .cp_tristate_o (cp_tristate_o)
);

// File: tb/serial_reg_loader_tb_top.sv
module serial_reg_loader_tb_top;
    import serload_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0;
    logic sclk  = 1'b0;
    logic sdata = 1'b0;
    logic sle   = 1'b0;
    logic ce    = 1'b1;
    logic [NUM_LATCH-1:0][PAY_W-1:0] latch_data;
    logic [NUM_LATCH-1:0]            upd;
    logic                            pd;
    logic                            cp_tri;

    serial_reg_loader dut_i (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .ser_clk_i     (sclk),
        .ser_data_i    (sdata),
        .ser_le_i      (sle),
        .chip_en_i     (ce),
        .latch_data_o  (latch_data),
        .latch_upd_o   (upd),
        .pwr_down_o    (pd),
        .cp_tristate_o (cp_tri)
    );

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;
    pay_t  exp_pay [NUM_LATCH];
    int    exp_cnt [NUM_LATCH];
    int    seen_cnt[NUM_LATCH];
    int    wide    = 0;
    logic [NUM_LATCH-1:0] upd_prev = '0;
    word_t sr_model = '0;

    function automatic pay_t payload_of(word_t w);
        return w[WORD_W-1:CTRL_W];
    endfunction

    function automatic int addr_of(word_t w);
        return int'(w[CTRL_W-1:0]);
    endfunction

    function automatic logic exp_pd();
        return !ce || exp_pay[0][19];
    endfunction

    // strobe monitor
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < NUM_LATCH; i++) begin
                if (upd[i]) seen_cnt[i]++;
            end
            if (|(upd & upd_prev)) wide++;
            upd_prev = upd;
        end else begin
            upd_prev = '0;
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    task automatic check_state(string req);
        for (int i = 0; i < NUM_LATCH; i++) begin
            chk(latch_data[i] == exp_pay[i], req, $sformatf("latch%0d data", i),
                32'(latch_data[i]), 32'(exp_pay[i]));
            chk(seen_cnt[i] == exp_cnt[i], req, $sformatf("latch%0d strobe count", i),
                32'(seen_cnt[i]), 32'(exp_cnt[i]));
        end
        chk(pd == exp_pd(), "R7", "pwr_down", 32'(pd), 32'(exp_pd()));
        chk(cp_tri == exp_pd(), "R8", "cp_tristate", 32'(cp_tri), 32'(exp_pd()));
    endtask

    task automatic model_load();
        exp_pay[addr_of(sr_model)] = payload_of(sr_model);
        exp_cnt[addr_of(sr_model)]++;
    endtask

    task automatic send_word(word_t w, bit coincide, int hold);
        for (int i = WORD_W - 1; i >= 0; i--) begin
            sdata = w[i];
            sclk  = 1'b0;
            tick(3);
            if (i == 0 && coincide) sle = 1'b1;
            sclk = 1'b1;
            tick(3);
        end
        sclk = 1'b0;
        if (!coincide) begin
            tick(3);
            sle = 1'b1;
        end
        tick(hold);
        sle = 1'b0;
        tick(8);
        sr_model = w;
        model_load();
    endtask

    task automatic le_only(int hold);
        sle = 1'b1;
        tick(hold);
        sle = 1'b0;
        tick(8);
        model_load();
    endtask

    initial begin
        for (int i = 0; i < NUM_LATCH; i++) begin
            exp_pay[i]  = '0;
            exp_cnt[i]  = 0;
            seen_cnt[i] = 0;
        end
        void'($urandom(32'h5eed_1234));
        tick(4);
        // R6: reset state
        for (int i = 0; i < NUM_LATCH; i++) begin
            chk(latch_data[i] == '0, "R6", "latch in reset", 32'(latch_data[i]), 32'h0);
        end
        chk(upd == '0, "R6", "strobes in reset", 32'(upd), 32'h0);
        chk(pd == 1'b1, "R7", "pwr_down in reset", 32'(pd), 32'h1);
        rst_n = 1'b1;
        tick(4);
        check_state("R6");

        // R5, R6: load with no bits after reset transfers zero word to latch 0
        le_only(3);
        check_state("R5");

        // R1, R2: each address, MSB-first marker words
        send_word(24'h800000, 1'b0, 3);
        check_state("R1");
        send_word(24'hA5A5A5, 1'b0, 3);
        check_state("R2");
        send_word(24'h3C3C3E, 1'b0, 3);
        check_state("R2");
        send_word(24'h5F0F0F, 1'b0, 3);
        check_state("R2");

        // R3: load strobe held high long
        send_word(24'h123455, 1'b0, 40);
        check_state("R3");

        // R5: repeat load with no new bits
        le_only(3);
        check_state("R5");

        // R9: coincident final clock edge and load edge
        send_word(24'hC0FFEE, 1'b1, 3);
        check_state("R9");
        send_word(24'h0F00D1, 1'b1, 3);
        check_state("R9");

        // R7, R8: power-down bit in latch 0 and chip enable
        send_word(24'h200000, 1'b0, 3);
        check_state("R7");
        send_word(24'h1FFFFC, 1'b0, 3);
        check_state("R7");
        ce = 1'b0;
        tick(5);
        check_state("R8");
        ce = 1'b1;
        tick(5);
        check_state("R7");

        // random words, random coincident ending
        for (int n = 0; n < 30; n++) begin
            word_t w;
            w = word_t'($urandom);
            send_word(w, bit'($urandom % 2), 3 + int'($urandom % 6));
            check_state("R2");
        end

        chk(wide == 0, "R4", "multi-cycle strobes", 32'(wide), 32'h0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule